// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Registers

This block is a multi-cycle 32-bit integer arithmetic unit. A one-cycle start pulse supplies an operation code and two operands. The unit then runs a fixed sequence of steps and writes its 64-bit result into two result registers, HI and LO. A multiply leaves the full product split across the pair. A divide leaves the remainder in HI and the quotient in LO. Both registers are always visible on output ports, so a core can copy either one into a general register. Either register can also be loaded directly from a write port.

The multiplier (shift-add) and the divider (restoring) share one adder and one shift path, and each runs one step per cycle. Signed operations take the magnitudes of the operands first and fix the signs in a final cycle. The unit never flags overflow or a zero divisor. Every operation finishes in the same number of cycles and always gives a defined result.

Top module: `muldiv_hilo`

## Requirements
- R1: With op = 2'b01 (unsigned multiply), {hi, lo} equals the 64-bit unsigned product of opa and opb.
- R2: With op = 2'b00 (signed multiply), {hi, lo} equals the 64-bit two's-complement product of opa and opb.
- R3: With op = 2'b11 (unsigned divide) and opb nonzero, lo is the unsigned quotient opa/opb and hi is the remainder.
- R4: With op = 2'b10 (signed divide) and opb nonzero, lo is the quotient rounded toward zero. hi is the remainder, which carries the sign of the dividend. The case -2^31 / -1 gives lo = 32'h8000_0000 and hi = 0.
- R5: A divide of either form with opb = 0 takes the normal cycle count, asserts no error, and gives lo = 32'hFFFF_FFFF and hi = opa.
- R6: Call the rising edge that samples start high while busy is low the accepting edge. busy is high for exactly 34 cycles after the accepting edge. In the following cycle busy is low, done is high for that one cycle only, and hi/lo already hold the new result.
- R7: A start pulse is ignored while busy is high. The running operation's result and timing are unchanged, and hi/lo keep their previous values until the operation completes.
- R8: While busy is low, wr_hi (or wr_lo) loads wr_data into hi (or lo), and the new value is visible after the next rising edge. While busy is high these writes have no effect.
- R9: After reset, hi and lo are zero and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand / dividend |
| opb | input | 32 | Multiplier / divisor |
| wr_hi | input | 1 | Direct write strobe for HI |
| wr_lo | input | 1 | Direct write strobe for LO |
| wr_data | input | 32 | Data for direct writes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | HI register (product upper half / remainder) |
| lo | output | 32 | LO register (product lower half / quotient) |

## Verification
The assertions assume start is a clean synchronous level. They also assume that a direct write made while the unit is idle is not asked to land in the same cycle as a completion, which cannot happen because completion only occurs while busy. The stimulus changes every input on the falling edge, holds start for exactly one cycle, and makes its stray start pulses and direct writes only in the middle of a running operation. The window between acceptance and completion is therefore always well defined when the timing and stability properties are checked.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ITER,
    ST_FIX
  } md_state_t;

  function automatic logic op_is_div(input logic [1:0] code);
    return code[1];
  endfunction

  function automatic logic op_is_signed(input logic [1:0] code);
    return ~code[0];
  endfunction
endpackage

// File: rtl/md_ctrl.sv
module md_ctrl import muldiv_pkg::*; #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic accept,
  output logic load,
  output logic step_en,
  output logic finish
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  md_state_t state;
  logic [CW-1:0] cnt;

  assign busy    = (state != ST_IDLE);
  assign accept  = start && !busy;
  assign load    = (state == ST_SETUP);
  assign step_en = (state == ST_ITER);
  assign finish  = (state == ST_FIX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (accept) state <= ST_SETUP;
        ST_SETUP: begin
          state <= ST_ITER;
          cnt   <= '0;
        end
        ST_ITER: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIX;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/md_step.sv
module md_step #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic [W-1:0] upper,
  input  logic [W-1:0] lower,
  input  logic [W-1:0] opnd,
  output logic         qbit,
  output logic [W-1:0] nxt_upper,
  output logic [W-1:0] nxt_lower
);
  localparam int AW = W + 2;

  logic [AW-1:0] lhs, rhs, sum;
  logic          cin;

  always_comb begin
    if (is_div) begin
      lhs = {1'b0, upper, lower[W-1]};
      rhs = {2'b11, ~opnd};
      cin = 1'b1;
    end else begin
      lhs = {2'b00, upper};
      rhs = lower[0] ? {2'b00, opnd} : '0;
      cin = 1'b0;
    end
    sum  = lhs + rhs + {{(AW-1){1'b0}}, cin};
    qbit = ~sum[AW-1];
    if (is_div) begin
      nxt_upper = qbit ? sum[W-1:0] : lhs[W-1:0];
      nxt_lower = {lower[W-2:0], qbit};
    end else begin
      nxt_upper = sum[W:1];
      nxt_lower = {sum[0], lower[W-1:1]};
    end
  end
endmodule

// File: rtl/md_hilo.sv
module md_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         finish,
  input  logic [W-1:0] res_hi,
  input  logic [W-1:0] res_lo,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi <= '0;
      lo <= '0;
    end else if (finish) begin
      hi <= res_hi;
      lo <= res_lo;
    end else if (!busy) begin
      if (wr_hi) hi <= wr_data;
      if (wr_lo) lo <= wr_data;
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo import muldiv_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  function automatic logic [W-1:0] neg_w(input logic [W-1:0] x);
    return ~x + 1'b1;
  endfunction

  function automatic logic [2*W-1:0] neg_2w(input logic [2*W-1:0] x);
    return ~x + 1'b1;
  endfunction

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic sgn);
    return sgn ? neg_w(x) : x;
  endfunction

  // named internal events, used by the bound checker
  logic accept, load, step_en, finish, qbit;

  logic [1:0]   op_q;
  logic [W-1:0] a_q, b_q;
  logic [W-1:0] upper, lower, opnd;
  logic         flip_main, flip_rem;
  logic [W-1:0] nxt_upper, nxt_lower;
  logic [W-1:0] res_hi, res_lo;
  logic         sa, sb, is_div_q;
  logic [2*W-1:0] prod_fix;

  md_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .accept(accept),
    .load(load), .step_en(step_en), .finish(finish)
  );

  assign is_div_q = op_is_div(op_q);
  assign sa = op_is_signed(op_q) & a_q[W-1];
  assign sb = op_is_signed(op_q) & b_q[W-1];

  md_step #(.W(W)) u_step (
    .is_div(is_div_q), .upper(upper), .lower(lower), .opnd(opnd),
    .qbit(qbit), .nxt_upper(nxt_upper), .nxt_lower(nxt_lower)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= '0;
      a_q       <= '0;
      b_q       <= '0;
      upper     <= '0;
      lower     <= '0;
      opnd      <= '0;
      flip_main <= 1'b0;
      flip_rem  <= 1'b0;
    end else if (accept) begin
      op_q <= op;
      a_q  <= opa;
      b_q  <= opb;
    end else if (load) begin
      upper <= '0;
      if (is_div_q) begin
        lower     <= magnitude(a_q, sa);
        opnd      <= magnitude(b_q, sb);
        flip_main <= (sa ^ sb) && (b_q != '0);
        flip_rem  <= sa;
      end else begin
        lower     <= magnitude(b_q, sb);
        opnd      <= magnitude(a_q, sa);
        flip_main <= sa ^ sb;
        flip_rem  <= 1'b0;
      end
    end else if (step_en) begin
      upper <= nxt_upper;
      lower <= nxt_lower;
    end
  end

  always_comb begin
    prod_fix = flip_main ? neg_2w({upper, lower}) : {upper, lower};
    if (is_div_q) begin
      res_hi = flip_rem  ? neg_w(upper) : upper;
      res_lo = flip_main ? neg_w(lower) : lower;
    end else begin
      res_hi = prod_fix[2*W-1:W];
      res_lo = prod_fix[W-1:0];
    end
  end

  md_hilo #(.W(W)) u_hilo (
    .clk(clk), .rst_n(rst_n), .busy(busy), .finish(finish),
    .res_hi(res_hi), .res_lo(res_lo), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .hi(hi), .lo(lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= finish;
  end
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         accept,
  input logic         finish,
  input logic         wr_hi,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int SPAN = W + 2;
  localparam int KW   = $clog2(SPAN + 2) + 1;

  logic [KW-1:0] run_len;
  logic          seen_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= '0;
      seen_busy <= 1'b0;
    end else begin
      seen_busy <= busy;
      if (accept)    run_len <= KW'(1);
      else if (busy) run_len <= run_len + 1'b1;
    end
  end

  // R6: an accepted start makes the unit busy on the next cycle
  a_r6_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R6: the last busy cycle is the 34th counted from acceptance
  a_r6_span_length: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (run_len == KW'(SPAN)));

  // R6: done is a single-cycle pulse seen with busy already low
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && seen_busy));

  // R7: result registers hold while an operation is mid-flight
  a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && seen_busy) |-> ($stable(hi) && $stable(lo)));

  // R8: an idle direct write to HI lands on the next edge
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_hi) |=> (hi == $past(wr_data)));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .accept(accept), .finish(finish), .wr_hi(wr_hi), .wr_data(wr_data),
  .hi(hi), .lo(lo)
);

// File: tb/muldiv_hilo_test.sv
module muldiv_hilo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0, wr_data = '0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  muldiv_hilo uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total = total + 1;
    if (got !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] ref_result(input logic [1:0] code,
                                             input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb, sp;
    logic [63:0] ua, ub;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'b0, a};
    ub = {32'b0, b};
    case (code)
      2'b01: return ua * ub;
      2'b00: begin sp = sa * sb; return sp; end
      2'b11: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {32'(ua % ub), 32'(ua / ub)};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {32'(sa % sb), 32'(sa / sb)};
      end
    endcase
  endfunction

  // launch one operation; optional stray start and direct writes mid-run
  task automatic run_op(input string tag, input logic [1:0] code,
                        input logic [31:0] a, input logic [31:0] b, input logic disturb);
    int busy_n;
    logic [31:0] hi0, lo0;
    logic [63:0] exp;
    exp = ref_result(code, a, b);
    hi0 = hi;
    lo0 = lo;
    @(negedge clk);
    start = 1'b1; op = code; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    busy_n = 0;
    while (!done && busy_n < 100) begin
      if (busy) busy_n++;
      if (disturb && busy_n == 10) begin
        start = 1'b1; op = ~code; opa = 32'h1234_5678; opb = 32'h3;
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hDEAD_BEEF;
      end else begin
        start = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
      end
      if (disturb && busy_n == 12) begin
        chk({tag, " R7 hi held mid-run"}, {32'b0, hi}, {32'b0, hi0});
        chk({tag, " R8 lo untouched by busy write"}, {32'b0, lo}, {32'b0, lo0});
      end
      @(negedge clk);
    end
    start = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
    chk({tag, " R6 busy cycles"}, 64'(busy_n), 64'd34);
    chk({tag, " R6 busy low at done"}, {63'b0, busy}, 64'd0);
    chk({tag, " result"}, {hi, lo}, exp);
    @(negedge clk);
    chk({tag, " R6 done one cycle"}, {63'b0, done}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R9 hi after reset", {32'b0, hi}, 64'd0);
    chk("R9 lo after reset", {32'b0, lo}, 64'd0);
    chk("R9 busy/done after reset", {62'b0, busy, done}, 64'd0);
  endtask

  task automatic t_mulu;
    run_op("R1 mulu max", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_op("R1 mulu mixed", 2'b01, 32'h0001_2345, 32'h0000_ABCD, 1'b0);
  endtask

  task automatic t_muls;
    run_op("R2 muls neg*pos", 2'b00, -32'sd3, 32'd7, 1'b0);
    run_op("R2 muls mostneg^2", 2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0);
    run_op("R2 muls zero", 2'b00, 32'd0, 32'hFFFF_FFF0, 1'b0);
  endtask

  task automatic t_divu;
    run_op("R3 divu 100/7", 2'b11, 32'd100, 32'd7, 1'b0);
    run_op("R3 divu max/1", 2'b11, 32'hFFFF_FFFF, 32'd1, 1'b0);
    run_op("R3 divu small/big", 2'b11, 32'd5, 32'hF000_0000, 1'b0);
  endtask

  task automatic t_divs;
    run_op("R4 divs -7/2", 2'b10, -32'sd7, 32'd2, 1'b0);
    run_op("R4 divs 7/-2", 2'b10, 32'd7, -32'sd2, 1'b0);
    run_op("R4 divs -7/-2", 2'b10, -32'sd7, -32'sd2, 1'b0);
    run_op("R4 divs mostneg/-1", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    chk("R4 mostneg/-1 lo", {32'b0, lo}, 64'h8000_0000);
  endtask

  task automatic t_divzero;
    run_op("R5 divu by zero", 2'b11, 32'h0BAD_F00D, 32'd0, 1'b0);
    run_op("R5 divs by zero neg", 2'b10, -32'sd5, 32'd0, 1'b0);
    chk("R5 divs zero lo", {32'b0, lo}, 64'hFFFF_FFFF);
  endtask

  task automatic t_ignore_busy;
    run_op("R7 stray start", 2'b01, 32'd1000, 32'd3000, 1'b1);
  endtask

  task automatic t_direct_write;
    @(negedge clk);
    wr_hi = 1'b1; wr_data = 32'hCAFE_0001;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 32'h0000_BEEF;
    chk("R8 hi written", {32'b0, hi}, 64'hCAFE_0001);
    @(negedge clk);
    wr_lo = 1'b0;
    chk("R8 lo written", {32'b0, lo}, 64'h0000_BEEF);
    chk("R8 hi kept", {32'b0, hi}, 64'hCAFE_0001);
  endtask

  initial begin
    #1;
    @(negedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_mulu;
    t_muls;
    t_divu;
    t_divs;
    t_divzero;
    t_ignore_busy;
    t_direct_write;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule